// File: doc/BRIEF.md
# Endian Bus-Width Downsizer

This block sits on the read side of a 36-bit first-in first-out buffer and presents each stored long word to a narrower consumer port. The consumer port is 36, 18 or 9 bits wide. A long word goes out whole, as two 18-bit halves, or as four 9-bit lanes. Each piece takes one read strobe, and the strobes may be spread over any number of cycles.

Two selects are sampled on every clock while reset is held and are frozen when reset is released. The width select sets the piece size. The order select sets whether the most significant piece leaves first (big-endian) or the least significant piece leaves first (little-endian). The buffer works in show-ahead style: its head word and a valid flag are always visible. The block asks the buffer to drop that head word only on the read that takes the word's final piece. The piece on the output is chosen by combinational logic from a small piece counter, so a read returns data in the same cycle it is issued.

Top module: `endian_downsizer`

## Requirements
- R1: The order select is captured while reset is low. A value of 1 gives big-endian order, where the most significant piece of a long word is read first. A value of 0 gives little-endian order, where the least significant piece is read first.
- R2: The width select is captured while reset is low. Changes to either select after reset is released have no effect until the next reset.
- R3: With width code 0 (full width), every read passes the complete 36-bit word, out_last is high, and the word is popped.
- R4: With width code 1 (half width), a word takes two reads. The halves are bits 17:0 and bits 35:18, and their order follows R1.
- R5: With width code 2 (lane width), a word takes four reads. The lanes are bits 8:0, 17:9, 26:18 and 35:27, and their order follows R1.
- R6: src_pop is high only in the cycle where rd_en and src_valid are both high and the final piece of the head word is being read.
- R7: out_last is high exactly when a valid word is present and its final piece is on out_data.
- R8: Output bits above the piece width are driven to zero in half-width and lane-width modes.
- R9: A read strobe while src_valid is low does not advance the piece position and does not pop. out_valid follows src_valid.
- R10: After reset, out_valid, out_last and src_pop are low when the buffer is empty, and the first read of the first word returns piece 0 of the order chosen by R1.
- R11: Width code 3 behaves as full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the selects are captured while it is low |
| cfg_size | input | 2 | Width select: 0 full, 1 half, 2 lane, 3 full |
| cfg_big | input | 1 | Order select: 1 big-endian, 0 little-endian |
| src_valid | input | 1 | Buffer head word is present |
| src_data | input | 36 | Buffer head word |
| src_pop | output | 1 | Drop the head word (final piece read) |
| rd_en | input | 1 | Consumer read strobe |
| out_valid | output | 1 | A piece is available on out_data |
| out_data | output | 36 | Current piece, zero-extended |
| out_last | output | 1 | Current piece is the final piece of its word |

## Verification
The assertions check, on every cycle, four things:
- the piece counter advances by one, wraps to zero or holds, as the read strobe and the valid flag dictate;
- the counter never passes the final piece for the captured width;
- a pop occurs only with a final-piece read;
- the padding bits stay zero and the captured selects stay frozen outside reset.

Only the bench scenarios can show that the pieces leave in the right order and from the right bit fields for each width and order combination. The same holds for showing that scrambling the selects after reset leaves the output unchanged.

// File: rtl/dsz_pkg.sv
package dsz_pkg;

   typedef enum logic [1:0] {
      DSZ_FULL = 2'd0,
      DSZ_HALF = 2'd1,
      DSZ_LANE = 2'd2
   } dsz_mode_e;

   // Width code 3 folds onto full width
   function automatic dsz_mode_e dsz_decode(input logic [1:0] code);
      case (code)
         2'd1:    return DSZ_HALF;
         2'd2:    return DSZ_LANE;
         default: return DSZ_FULL;
      endcase
   endfunction

endpackage

// File: rtl/dsz_cfg_latch.sv
module dsz_cfg_latch
   import dsz_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] cfg_size_i,
   input  logic       cfg_big_i,
   output dsz_mode_e  mode_o,
   output logic       big_o
);

   dsz_mode_e mode_q;
   logic      big_q;

   // Selects track their inputs while reset is held, then freeze
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= dsz_decode(cfg_size_i);
         big_q  <= cfg_big_i;
      end
   end

   assign mode_o = mode_q;
   assign big_o  = big_q;

   // R2
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ($stable(mode_q) && $stable(big_q)));

endmodule

// File: rtl/dsz_seq.sv
module dsz_seq
   import dsz_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  dsz_mode_e                mode_i,
   input  logic                     rd_en_i,
   input  logic                     src_valid_i,
   output logic [$clog2(LANES)-1:0] idx_o,
   output logic                     last_o,
   output logic                     pop_o
);

   localparam int IDX_W = $clog2(LANES);

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] top_idx;
   logic             step;

   always_comb begin
      case (mode_i)
         DSZ_HALF: top_idx = IDX_W'(1);
         DSZ_LANE: top_idx = IDX_W'(LANES - 1);
         default:  top_idx = '0;
      endcase
   end

   assign step   = rd_en_i & src_valid_i;
   assign last_o = (idx_q == top_idx);
   assign pop_o  = step & last_o;
   assign idx_o  = idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx_q <= '0;
      else if (step)
         idx_q <= last_o ? '0 : idx_q + IDX_W'(1);
   end

   // R4 R5
   advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && src_valid_i && !last_o) |=> (idx_q == $past(idx_q) + IDX_W'(1)));

   // R6
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && src_valid_i && last_o) |=> (idx_q == '0));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en_i && src_valid_i) |=> $stable(idx_q));

   // R3 R4
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= top_idx);

endmodule

// File: rtl/dsz_lane_mux.sv
module dsz_lane_mux
   import dsz_pkg::*;
#(
   parameter int LANE_W = 9,
   parameter int LANES  = 4
) (
   input  logic [LANE_W*LANES-1:0]  word_i,
   input  dsz_mode_e                mode_i,
   input  logic                     big_i,
   input  logic [$clog2(LANES)-1:0] idx_i,
   output logic [LANE_W*LANES-1:0]  data_o
);

   localparam int WORD_W = LANE_W * LANES;
   localparam int HALF_W = WORD_W / 2;
   localparam int IDX_W  = $clog2(LANES);

   logic [HALF_W-1:0] half_seg [2];
   logic [LANE_W-1:0] lane_seg [LANES];
   logic              sel_h;
   logic [IDX_W-1:0]  sel_l;

   for (genvar g = 0; g < 2; g++) begin : g_half
      assign half_seg[g] = word_i[g*HALF_W +: HALF_W];
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_seg[g] = word_i[g*LANE_W +: LANE_W];
   end

   // Big-endian walks the segments from the top down
   assign sel_h = big_i ? ~idx_i[0] : idx_i[0];
   assign sel_l = big_i ? (IDX_W'(LANES - 1) - idx_i) : idx_i;

   always_comb begin
      case (mode_i)
         DSZ_HALF: data_o = {{(WORD_W-HALF_W){1'b0}}, half_seg[sel_h]};
         DSZ_LANE: data_o = {{(WORD_W-LANE_W){1'b0}}, lane_seg[sel_l]};
         default:  data_o = word_i;
      endcase
   end

endmodule

// File: rtl/endian_downsizer.sv
module endian_downsizer
   import dsz_pkg::*;
#(
   parameter int LANE_W = 9,
   parameter int LANES  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              cfg_size,
   input  logic                    cfg_big,
   input  logic                    src_valid,
   input  logic [LANE_W*LANES-1:0] src_data,
   output logic                    src_pop,
   input  logic                    rd_en,
   output logic                    out_valid,
   output logic [LANE_W*LANES-1:0] out_data,
   output logic                    out_last
);

   localparam int WORD_W = LANE_W * LANES;
   localparam int HALF_W = WORD_W / 2;
   localparam int IDX_W  = $clog2(LANES);

   if (LANES < 2 || (1 << IDX_W) != LANES) begin : g_bad_lanes
      $error("LANES must be a power of two, at least 2");
   end
   if (LANE_W < 1) begin : g_bad_width
      $error("LANE_W must be positive");
   end

   dsz_mode_e        mode;
   logic             big;
   logic [IDX_W-1:0] idx;
   logic             seq_last;
   logic             seq_pop;

   dsz_cfg_latch u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_size_i (cfg_size),
      .cfg_big_i  (cfg_big),
      .mode_o     (mode),
      .big_o      (big)
   );

   dsz_seq #(.LANES(LANES)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (mode),
      .rd_en_i     (rd_en),
      .src_valid_i (src_valid),
      .idx_o       (idx),
      .last_o      (seq_last),
      .pop_o       (seq_pop)
   );

   dsz_lane_mux #(.LANE_W(LANE_W), .LANES(LANES)) u_mux (
      .word_i (src_data),
      .mode_i (mode),
      .big_i  (big),
      .idx_i  (idx),
      .data_o (out_data)
   );

   assign out_valid = src_valid;
   assign out_last  = src_valid & seq_last;
   assign src_pop   = seq_pop;

   // R6
   pop_needs_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_pop |-> (out_last && rd_en));

   // R8
   half_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == DSZ_HALF) |-> (out_data[WORD_W-1:HALF_W] == '0));

   // R8
   lane_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == DSZ_LANE) |-> (out_data[WORD_W-1:LANE_W] == '0));

   // R3
   full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == DSZ_FULL && src_valid) |-> (out_data == src_data && out_last));

endmodule

// File: tb/sim_endian_downsizer.sv
module sim_endian_downsizer;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_size = 2'd0;
   logic        cfg_big = 1'b0;
   logic        src_valid = 1'b0;
   logic [35:0] src_data = '0;
   logic        src_pop;
   logic        rd_en = 1'b0;
   logic        out_valid;
   logic [35:0] out_data;
   logic        out_last;

   int          checks = 0;
   int          fails = 0;
   bit          done = 0;
   logic [35:0] q[$];
   int          k = 0;
   int          lat_size = 0;
   bit          lat_big = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   endian_downsizer u0 (
      .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_big(cfg_big),
      .src_valid(src_valid), .src_data(src_data), .src_pop(src_pop),
      .rd_en(rd_en), .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
   );

   function automatic int n_pieces(input int sz);
      if (sz == 1) return 2;
      if (sz == 2) return 4;
      return 1;
   endfunction

   function automatic logic [35:0] exp_piece(input logic [35:0] w, input int sz,
                                             input bit be, input int idx);
      int n = n_pieces(sz);
      int wd = 36 / n;
      int seg = be ? (n - 1 - idx) : idx;
      logic [35:0] mask = (n == 1) ? {36{1'b1}} : ((36'd1 << wd) - 36'd1);
      return (w >> (seg * wd)) & mask;
   endfunction

   task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic refresh();
      src_valid = (q.size() > 0);
      src_data  = (q.size() > 0) ? q[0] : 36'h0;
   endtask

   task automatic step(input bit rd);
      int n = n_pieces(lat_size);
      string dtag;
      @(negedge clk);
      rd_en = rd;
      #1;
      if (lat_size == 3)      dtag = "R11 R1 R2";
      else if (lat_size == 1) dtag = "R4 R1 R2";
      else if (lat_size == 2) dtag = "R5 R1 R2";
      else                    dtag = "R3 R1 R2";
      if (q.size() > 0) begin
         chk("R9 out_valid", 36'(out_valid), 36'd1);
         chk(dtag, out_data, exp_piece(q[0], lat_size, lat_big, k));
         chk("R7 out_last", 36'(out_last), 36'(k == n - 1));
         chk("R6 src_pop", 36'(src_pop), 36'(rd && (k == n - 1)));
         if (n > 1) chk("R8 padding", out_data >> (36 / n), 36'd0);
      end else begin
         chk("R9 out_valid empty", 36'(out_valid), 36'd0);
         chk("R9 src_pop empty", 36'(src_pop), 36'd0);
      end
      @(posedge clk);
      #1;
      if (rd && q.size() > 0) begin
         if (k == n - 1) begin
            void'(q.pop_front());
            k = 0;
         end else begin
            k++;
         end
      end
      refresh();
   endtask

   task automatic scenario(input int sz, input bit be);
      @(negedge clk);
      rst_n = 1'b0; rd_en = 1'b0; cfg_size = 2'(sz); cfg_big = be;
      q.delete(); k = 0; refresh();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10 reset state
      chk("R10 out_valid", 36'(out_valid), 36'd0);
      chk("R10 out_last", 36'(out_last), 36'd0);
      chk("R10 src_pop", 36'(src_pop), 36'd0);
      rst_n = 1'b1;
      lat_size = sz; lat_big = be;
      // R9 strobes on an empty buffer
      repeat (3) step(1'b1);
      q.push_back(36'h0);
      q.push_back(36'hF_FFFF_FFFF);
      q.push_back(36'h8_0000_0001);
      q.push_back(36'h1_2345_6789);
      for (int i = 0; i < 16; i++) q.push_back({4'($urandom), $urandom});
      refresh();
      for (int guard = 0; guard < 400 && q.size() > 0; guard++) begin
         // R2: scramble the selects after reset release
         cfg_size = 2'($urandom);
         cfg_big  = 1'($urandom);
         step($urandom_range(0, 9) < 7);
      end
      repeat (2) step(1'b1);
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (2) @(posedge clk);
      for (int sz = 0; sz < 4; sz++) begin
         scenario(sz, 1'b0);
         scenario(sz, 1'b1);
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R6 watchdog expired actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule